// File: doc/BRIEF.md
# Character-Cell Overlay Raster Address Generator

This block turns a pixel clock and two sync strobes into cell coordinates for a text overlay of 24 columns by 12 rows. Each glyph cell is 12 dots wide and 18 scan lines tall. A horizontal strobe starts a new line. A vertical strobe starts a new frame. On every pixel clock the block reports the text column and row, the dot inside the cell and the scan line inside the cell, and it raises a display-enable while the raster is inside the text window. A character fetch unit and a glyph store sit downstream. They use the coordinates to pick a character and a glyph bit.

Two 6-bit position codes move the window away from the sync points. Two 2-bit size codes stretch the cells along each axis. The fetch path returns a per-character blink request, and the block gates display-enable with it against a slow phase taken from a frame counter.

Top module: `osd_raster_gen`

## Requirements
- R1: While reset is low, and after it until the first strobe, `col`, `row`, `dot`, `scan` and `disp_en` are all 0.
- R2: Let p be the number of clock edges since the edge that sampled `hsync` high, so that edge gives p = 0. The horizontal window opens at p = 4·`hpos`. With `hpos` = 0 it opens on the strobe edge itself.
- R3: Inside the horizontal window, with q = p − 4·`hpos` and m = `hsize`+1 (code 0 gives 1, 1 gives 2, 2 gives 3, 3 gives 4), `col` = q / (12m) and `dot` = (q mod 12m) / m. The window lasts 288m pixel clocks.
- R4: Let L be the number of `hsync` edges since the edge that sampled `vsync` high, so that edge gives L = 0. The vertical window opens at L = 4·`vpos`.
- R5: Inside the vertical window, with r = L − 4·`vpos` and n = `vsize`+1, `row` = r / (18n) and `scan` = (r mod 18n) / n. The window lasts 216n lines.
- R6: Outside its window, each axis reports index 0 and in-cell position 0.
- R7: `disp_en` is high only when both windows are open and the blanking of R8 does not apply.
- R8: A frame counter of BLINK_W bits counts `vsync` edges from 0 after reset. Its top bit is the blink phase. `blink_attr` is sampled on the same edge as the raster position. While both the phase and the sampled attribute are 1, `disp_en` is 0.
- R9: While the blink phase is 0, `blink_attr` has no effect on `disp_en`.
- R10: When `vsync` and `hsync` are high on the same edge, the vertical count restarts at L = 0 rather than advancing.
- R11: After a horizontal window closes, it stays closed until the next `hsync`. The vertical window likewise stays closed until the next `vsync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | One-clock line start strobe |
| vsync | input | 1 | One-clock frame start strobe |
| hpos | input | 6 | Horizontal start, 4 pixels per step |
| vpos | input | 6 | Vertical start, 4 lines per step |
| hsize | input | 2 | Horizontal magnification code |
| vsize | input | 2 | Vertical magnification code |
| blink_attr | input | 1 | Blink request of the current character |
| col | output | 5 | Text column 0..23 |
| row | output | 4 | Text row 0..11 |
| dot | output | 4 | Dot within the cell 0..11 |
| scan | output | 5 | Scan line within the cell 0..17 |
| disp_en | output | 1 | Overlay pixel enable |

## Verification
The hardest corner to reach is the bottom of a fully offset, fully magnified vertical window. It opens 252 lines down and runs for 864 lines. At a realistic line length that costs well over a million clocks. The stimulus therefore uses lines only a few clocks long, because the vertical axis advances only on line strobes. Long lines are kept for the horizontal sweeps. The blink phase would take many frames at its default width, so the bench builds the block with a 2-bit frame counter and steps through short frames with the blink request held high. This shows both the blanked phase and the unaffected phase.

// File: rtl/osd_raster_pkg.sv
package osd_raster_pkg;
  localparam int unsigned TEXT_COLS   = 24;
  localparam int unsigned TEXT_ROWS   = 12;
  localparam int unsigned GLYPH_W     = 12;
  localparam int unsigned GLYPH_H     = 18;
  localparam int unsigned OFFSET_UNIT = 4;
  localparam int unsigned OFF_W       = 6;
  localparam int unsigned MAG_W       = 2;

  // Raster units between the sync point and the window edge.
  function automatic int unsigned start_of(input logic [OFF_W-1:0] code,
                                           input int unsigned unit);
    return int'(code) * unit;
  endfunction

  // Replication factor selected by a size code (1..2**MAG_W).
  function automatic int unsigned mag_factor(input logic [MAG_W-1:0] code);
    return int'(code) + 1;
  endfunction
endpackage

// File: rtl/osd_cell_axis.sv
// One raster axis: a position counter since the restart strobe, and a
// cell walker (replica, in-cell position, cell index) inside the window.
module osd_cell_axis #(
  parameter int unsigned CELLS = 24,
  parameter int unsigned CELL  = 12,
  parameter int unsigned UNIT  = 4,
  parameter int unsigned OFF_W = 6,
  parameter int unsigned MAG_W = 2,
  localparam int unsigned IDX_W = $clog2(CELLS),
  localparam int unsigned SUB_W = $clog2(CELL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [OFF_W-1:0] off_code,
  input  logic [MAG_W-1:0] mag_code,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic [SUB_W-1:0] sub
);
  localparam int unsigned SPAN  = CELLS * CELL * (1 << MAG_W)
                                + ((1 << OFF_W) - 1) * UNIT + 2;
  localparam int unsigned POS_W = $clog2(SPAN);
  localparam logic [POS_W-1:0] POS_TOP = '1;

  logic [POS_W-1:0] pos_q;
  logic [MAG_W-1:0] rep_q;
  logic [SUB_W-1:0] sub_q;
  logic [IDX_W-1:0] idx_q;
  logic             act_q;

  logic [POS_W:0] start_w;
  logic [POS_W:0] pos_inc;
  logic           at_top, enter, last_rep, last_sub, last_idx, leave;

  assign start_w  = (POS_W+1)'(osd_raster_pkg::start_of(off_code, UNIT));
  assign pos_inc  = {1'b0, pos_q} + 1'b1;
  assign at_top   = (pos_q == POS_TOP);
  assign enter    = !act_q && !at_top && (pos_inc == start_w);
  assign last_rep = ((int'(rep_q) + 1) == osd_raster_pkg::mag_factor(mag_code));
  assign last_sub = (sub_q == SUB_W'(CELL - 1));
  assign last_idx = (idx_q == IDX_W'(CELLS - 1));
  assign leave    = act_q && last_rep && last_sub && last_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= POS_TOP;
      act_q <= 1'b0;
      rep_q <= '0;
      sub_q <= '0;
      idx_q <= '0;
    end else if (restart) begin
      pos_q <= '0;
      act_q <= (start_w == '0);
      rep_q <= '0;
      sub_q <= '0;
      idx_q <= '0;
    end else if (step) begin
      if (!at_top) pos_q <= pos_inc[POS_W-1:0];
      if (enter) begin
        act_q <= 1'b1;
      end else if (leave) begin
        act_q <= 1'b0;
        rep_q <= '0;
        sub_q <= '0;
        idx_q <= '0;
      end else if (act_q) begin
        if (last_rep) begin
          rep_q <= '0;
          if (last_sub) begin
            sub_q <= '0;
            idx_q <= idx_q + 1'b1;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end else begin
          rep_q <= rep_q + 1'b1;
        end
      end
    end
  end

  assign active = act_q;
  assign idx    = idx_q;
  assign sub    = sub_q;
endmodule

// File: rtl/osd_blink_div.sv
// Frame counter whose top bit is the blink phase.
module osd_blink_div #(
  parameter int unsigned BW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_tick,
  output logic          phase,
  output logic [BW-1:0] count
);
  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (frame_tick) cnt_q <= cnt_q + 1'b1;
  end

  assign phase = cnt_q[BW-1];
  assign count = cnt_q;
endmodule

// File: rtl/osd_raster_gen.sv
module osd_raster_gen #(
  parameter int unsigned COLS    = osd_raster_pkg::TEXT_COLS,
  parameter int unsigned ROWS    = osd_raster_pkg::TEXT_ROWS,
  parameter int unsigned CELL_W  = osd_raster_pkg::GLYPH_W,
  parameter int unsigned CELL_H  = osd_raster_pkg::GLYPH_H,
  parameter int unsigned UNIT    = osd_raster_pkg::OFFSET_UNIT,
  parameter int unsigned OFF_W   = osd_raster_pkg::OFF_W,
  parameter int unsigned MAG_W   = osd_raster_pkg::MAG_W,
  parameter int unsigned BLINK_W = 5,
  localparam int unsigned COL_W  = $clog2(COLS),
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned DOT_W  = $clog2(CELL_W),
  localparam int unsigned SCAN_W = $clog2(CELL_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [OFF_W-1:0]  hpos,
  input  logic [OFF_W-1:0]  vpos,
  input  logic [MAG_W-1:0]  hsize,
  input  logic [MAG_W-1:0]  vsize,
  input  logic              blink_attr,
  output logic [COL_W-1:0]  col,
  output logic [ROW_W-1:0]  row,
  output logic [DOT_W-1:0]  dot,
  output logic [SCAN_W-1:0] scan,
  output logic              disp_en
);
  // Named internal events, visible to the bound checker.
  logic               h_act;
  logic               v_act;
  logic               blink_phase;
  logic [BLINK_W-1:0] blink_cnt;
  logic               blk_q;

  // Horizontal axis: restarts on a line strobe and steps every pixel.
  osd_cell_axis #(
    .CELLS(COLS), .CELL(CELL_W), .UNIT(UNIT), .OFF_W(OFF_W), .MAG_W(MAG_W)
  ) h_axis_i (
    .clk(clk), .rst_n(rst_n), .restart(hsync), .step(1'b1),
    .off_code(hpos), .mag_code(hsize),
    .active(h_act), .idx(col), .sub(dot)
  );

  // Vertical axis: restarts on a frame strobe and steps on line strobes.
  osd_cell_axis #(
    .CELLS(ROWS), .CELL(CELL_H), .UNIT(UNIT), .OFF_W(OFF_W), .MAG_W(MAG_W)
  ) v_axis_i (
    .clk(clk), .rst_n(rst_n), .restart(vsync), .step(hsync),
    .off_code(vpos), .mag_code(vsize),
    .active(v_act), .idx(row), .sub(scan)
  );

  osd_blink_div #(.BW(BLINK_W)) blink_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(vsync),
    .phase(blink_phase), .count(blink_cnt)
  );

  // Blink request lines up with the raster position of the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n) blk_q <= 1'b0;
    else        blk_q <= blink_attr;
  end

  assign disp_en = h_act && v_act && !(blk_q && blink_phase);
endmodule

// File: rtl/osd_raster_chk.sv
module osd_raster_chk #(
  parameter int unsigned COL_W  = 5,
  parameter int unsigned ROW_W  = 4,
  parameter int unsigned DOT_W  = 4,
  parameter int unsigned SCAN_W = 5,
  parameter int unsigned OFF_W  = 6,
  parameter int unsigned MAG_W  = 2,
  parameter int unsigned BW     = 5,
  parameter int unsigned CELL_W = 12,
  parameter int unsigned CELL_H = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsync,
  input logic              vsync,
  input logic [OFF_W-1:0]  hpos,
  input logic [OFF_W-1:0]  vpos,
  input logic [MAG_W-1:0]  hsize,
  input logic              h_act,
  input logic              v_act,
  input logic [COL_W-1:0]  col,
  input logic [ROW_W-1:0]  row,
  input logic [DOT_W-1:0]  dot,
  input logic [SCAN_W-1:0] scan,
  input logic              disp_en,
  input logic [BW-1:0]     blink_cnt
);
  AST_DOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dot) < CELL_W); // R3
  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(scan) < CELL_H); // R5
  AST_H_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !h_act |-> (col == '0 && dot == '0)); // R6
  AST_V_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !v_act |-> (row == '0 && scan == '0)); // R6
  AST_EN_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> (h_act && v_act)); // R7
  AST_HSYNC_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && hpos != '0) |=> !h_act); // R2
  AST_VSYNC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && vpos != '0) |=> (!v_act && row == '0)); // R10
  AST_DOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (h_act && !hsync && hsize == '0 && int'(dot) != CELL_W - 1)
      |=> (dot == $past(dot) + 1'b1)); // R3
  AST_BLINK_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (blink_cnt == $past(blink_cnt) + 1'b1)); // R8
  AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(blink_cnt)); // R8
endmodule

bind osd_raster_gen osd_raster_chk #(
  .COL_W(COL_W), .ROW_W(ROW_W), .DOT_W(DOT_W), .SCAN_W(SCAN_W),
  .OFF_W(OFF_W), .MAG_W(MAG_W), .BW(BLINK_W), .CELL_W(CELL_W), .CELL_H(CELL_H)
) chk_i (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .hpos(hpos),
  .vpos(vpos), .hsize(hsize), .h_act(h_act), .v_act(v_act), .col(col),
  .row(row), .dot(dot), .scan(scan), .disp_en(disp_en), .blink_cnt(blink_cnt)
);

// File: tb/osd_raster_gen_tb_top.sv
module osd_raster_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BW         = 2;
  localparam int SAT        = 4095;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync = 1'b0, vsync = 1'b0, blink_attr = 1'b0;
  logic [5:0] hpos = '0, vpos = '0;
  logic [1:0] hsize = '0, vsize = '0;
  logic [4:0] col;
  logic [3:0] row;
  logic [3:0] dot;
  logic [4:0] scan;
  logic       disp_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_raster_gen #(.BLINK_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .hpos(hpos), .vpos(vpos), .hsize(hsize), .vsize(vsize),
    .blink_attr(blink_attr), .col(col), .row(row), .dot(dot),
    .scan(scan), .disp_en(disp_en)
  );

  typedef struct {
    int tgt;
    int en;
    int col;
    int row;
    int dot;
    int scan;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  // Bench model state
  int p = SAT;
  int L = SAT;
  int frames = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  // Driver: apply one clock of stimulus and queue what the design must show
  // after the next rising edge.
  task automatic step(input bit hs, input bit vs, input bit ba);
    exp_t e;
    int mh, mv, hs0, vs0, q, r, ph;
    bit inh, inv;
    hsync = hs; vsync = vs; blink_attr = ba;
    if (vs) begin L = 0; frames++; end          // R10: frame strobe wins
    else if (hs) begin if (L < SAT) L++; end
    if (hs) p = 0; else if (p < SAT) p++;
    mh = int'(hsize) + 1; mv = int'(vsize) + 1;
    hs0 = 4 * int'(hpos); vs0 = 4 * int'(vpos);
    inh = (p >= hs0) && (p < hs0 + 288 * mh);   // R2 R11
    inv = (L >= vs0) && (L < vs0 + 216 * mv);   // R4 R11
    e.tgt = cyc + 1;
    e.col = 0; e.dot = 0; e.row = 0; e.scan = 0;
    if (inh) begin
      q = p - hs0;
      e.col = q / (12 * mh);
      e.dot = (q % (12 * mh)) / mh;
    end
    if (inv) begin
      r = L - vs0;
      e.row = r / (18 * mv);
      e.scan = (r % (18 * mv)) / mv;
    end
    ph = (frames >> (BW - 1)) & 1;
    e.en = (inh && inv && !(ba && ph == 1)) ? 1 : 0;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic run_line(input int len, input bit ba);
    step(1'b1, 1'b0, ba);
    for (int i = 1; i < len; i++) step(1'b0, 1'b0, ba);
  endtask

  // Monitor: compare queued expectations once their edge has passed.
  always @(negedge clk) begin
    exp_t e;
    while (exp_q.size() > 0 && exp_q[0].tgt <= cyc) begin
      e = exp_q.pop_front();
      chk("R3 R6", "col", int'(col), e.col);
      chk("R3 R6", "dot", int'(dot), e.dot);
      chk("R5 R6", "row", int'(row), e.row);
      chk("R5 R6", "scan", int'(scan), e.scan);
      chk("R7 R8 R9", "disp_en", int'(disp_en), e.en);
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "col", int'(col), 0);
    chk("R1", "row", int'(row), 0);
    chk("R1", "dot", int'(dot), 0);
    chk("R1", "scan", int'(scan), 0);
    chk("R1", "disp_en", int'(disp_en), 0);
    rst_n = 1'b1;
    // R1: nothing opens before the first strobe
    repeat (6) step(1'b0, 1'b0, 1'b0);

    // R2 R3 R11: small offset, unit size, tail after the window closes
    hpos = 6'd3; hsize = 2'd0; vpos = 6'd0; vsize = 2'd0;
    step(1'b0, 1'b1, 1'b0);
    run_line(320, 1'b0);
    // R2 R3: largest offset, triple width
    hpos = 6'd63; hsize = 2'd2;
    run_line(1150, 1'b0);
    // R2 R3: zero offset opens on the strobe edge, quadruple width
    hpos = 6'd0; hsize = 2'd3;
    run_line(1180, 1'b0);
    // R3: double width, odd offset
    hpos = 6'd5; hsize = 2'd1;
    run_line(620, 1'b0);

    // R4 R5 R11: vertical sweep with short lines, offset 8, quadruple height
    hpos = 6'd0; hsize = 2'd0; vpos = 6'd2; vsize = 2'd3;
    step(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 880; i++) run_line(4, 1'b0);
    // R4 R5: zero offset, double height
    vpos = 6'd0; vsize = 2'd1;
    step(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 440; i++) run_line(3, 1'b0);
    // R5: triple height, offset 4
    vpos = 6'd1; vsize = 2'd2;
    step(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 660; i++) run_line(3, 1'b0);

    // R10: coincident strobes restart the vertical count
    vpos = 6'd1; vsize = 2'd0;
    for (int i = 0; i < 6; i++) run_line(4, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 10; i++) run_line(4, 1'b0);

    // R8 R9: blink request held high across frames of both phases
    vpos = 6'd0; vsize = 2'd0; hpos = 6'd0; hsize = 2'd0;
    for (int f = 0; f < 8; f++) begin
      step(1'b0, 1'b1, 1'b1);
      run_line(20, 1'b1);
      run_line(20, 1'b0);
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule